// File: doc/BRIEF.md
# Committed-Store Retirement Queue

This block holds the stores of an out-of-order core from dispatch until the data cache has accepted and acknowledged them. Each store is written at the tail of a circular ring. It carries its sequence number, the load-queue position current at dispatch, an address, data and a byte count. The commit stage presents the sequence number of the youngest instruction it has retired. Stores up to that point become eligible to leave the ring. A writeback pointer then sends eligible stores to the cache in program order, up to a set number per cycle.

Acknowledgements may come back in any order and name the slot they belong to. The ring still gives slots back strictly oldest first. A slot is freed only once every older slot has been acknowledged. A squash trims speculative stores off the young end. It never touches a store that has already been made eligible.

The ring has one spare slot, so full and empty can be told apart from the pointers alone. Slot numbers run from 0 to DEPTH and wrap.

Top module: `store_queue`

## Requirements
- R1: After reset the queue holds no entries: `count` is 0, `full` is 0, `allocIdx` is 0 and no request lane is valid.
- R2: An allocation writes the slot shown on `allocIdx` and moves the tail on by one. At most DEPTH entries are held, and `full` is high exactly when DEPTH entries are held. An allocation offered while `full` is high changes nothing.
- R3: A commit walks from the oldest entry toward the youngest. It marks each not-yet-eligible entry as eligible, and stops at the first not-yet-eligible entry whose sequence number exceeds `commitSeq`. Only eligible entries are ever sent to the cache.
- R4: Requests leave in allocation order, at most PORTS per cycle. Lane 0 carries the oldest request, and the valid lanes are always the lowest-numbered ones.
- R5: While `cacheBlocked` is high no request lane is valid and no store is lost. The same stores are offered once the block lifts.
- R6: An eligible entry with byte count 0 completes in the cycle it is reached. It uses no request lane, and the next store may take lane 0 in that same cycle.
- R7: The size field is a byte count. The legal values are 1, 2, 4 and 8, and 0 means no data. `sizeError` is high in any cycle in which a valid lane carries any other value, and low otherwise.
- R8: `rspIdx` names the acknowledged slot. Acknowledgements may arrive in any order. Slots are released only while the oldest held entry is complete, so `count` falls only when the head is acknowledged. It then drops past all contiguous completed entries at once.
- R9: A squash walks back from the youngest entry, removing each entry whose sequence number exceeds `squashSeq`. It halts at the first eligible entry or at the first entry that is not younger than `squashSeq`.
- R10: When a squash and an allocation arrive in the same cycle, the squash is carried out and the allocation is dropped.
- R11: Slot numbers count up to DEPTH and then wrap to 0, so with DEPTH=4 successive slots run 2, 3, 4, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate a store at the tail |
| allocSeq | input | SEQ_W | Sequence number of the new store |
| allocLqTag | input | LQ_W | Load-queue tail at dispatch |
| allocAddr | input | ADDR_W | Store address |
| allocData | input | DATA_W | Store data |
| allocSize | input | 4 | Byte count (0,1,2,4,8 legal) |
| allocIdx | output | IDX_W | Slot the next allocation will take |
| full | output | 1 | DEPTH entries held |
| count | output | CNT_W | Entries held |
| commitValid | input | 1 | Commit strobe |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| squashValid | input | 1 | Squash strobe |
| squashSeq | input | SEQ_W | Entries younger than this are removed |
| cacheBlocked | input | 1 | Cache cannot accept requests this cycle |
| reqValid | output | PORTS | Request valid per lane |
| reqIdx | output | PORTS*IDX_W | Slot number per lane |
| reqAddr | output | PORTS*ADDR_W | Address per lane |
| reqData | output | PORTS*DATA_W | Data per lane |
| reqSize | output | PORTS*4 | Byte count per lane |
| reqLqTag | output | PORTS*LQ_W | Load-queue tag per lane |
| sizeError | output | 1 | A valid lane carries an illegal size |
| rspValid | input | 1 | Acknowledgement strobe |
| rspIdx | input | IDX_W | Acknowledged slot |

## Verification
The bench answers the head slot last while younger slots are already acknowledged. A queue that frees each slot as it is answered would lose `count` early. A squash is aimed both at an eligible entry and at a plain older one. A walk that ignores either stop would remove stores the commit stage has already retired. A zero-byte store is placed ahead of a real one, and more stores are made eligible than there are lanes. This exposes lane packing that leaves holes, a zero store that eats a lane, or a port limit that is off by one. The ring is also driven across its wrap point, and allocation is raced against a squash.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SIZE_W = 4;

  function automatic logic sizeLegal(input logic [SIZE_W-1:0] s);
    return (s == 4'd1) || (s == 4'd2) || (s == 4'd4) || (s == 4'd8);
  endfunction
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
  parameter int SLOTS = 5,
  parameter int PORTS = 2,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter type strobe_t = logic
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   allocValid,
  input  logic                   commitValid,
  input  logic [SEQ_W-1:0]       commitSeq,
  input  logic                   squashValid,
  input  logic [SEQ_W-1:0]       squashSeq,
  input  logic                   cacheBlocked,
  input  logic                   rspValid,
  input  logic [IDX_W-1:0]       rspIdx,
  input  logic [SEQ_W-1:0]       entSeq [SLOTS],
  input  logic [3:0]             entSize [SLOTS],
  input  logic [SLOTS-1:0]       eligible,
  input  logic [SLOTS-1:0]       sent,
  input  logic [SLOTS-1:0]       done,
  output strobe_t                strobe,
  output logic [PORTS-1:0]       laneValid,
  output logic [PORTS*IDX_W-1:0] laneIdx,
  output logic [IDX_W-1:0]       allocIdx,
  output logic                   full,
  output logic [CNT_W-1:0]       count
);
  localparam int LANE_W = $clog2(PORTS + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] headPtr, wbPtr, tailPtr;
  logic [CNT_W-1:0] toWrite;

  function automatic logic [IDX_W-1:0] wrapInc(input logic [IDX_W-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] wrapDec(input logic [IDX_W-1:0] i);
    return (i == '0) ? LAST : i - 1'b1;
  endfunction

  // commit walk
  logic [SLOTS-1:0] eligSetV, eligAfter;
  logic [CNT_W-1:0] marks;
  always_comb begin
    logic [IDX_W-1:0] idx;
    logic stop;
    eligSetV = '0;
    marks = '0;
    idx = headPtr;
    stop = !commitValid;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        if (idx == tailPtr) stop = 1'b1;
        else if (!eligible[idx] && entSeq[idx] > commitSeq) stop = 1'b1;
        else begin
          if (!eligible[idx]) begin
            eligSetV[idx] = 1'b1;
            marks = marks + 1'b1;
          end
          idx = wrapInc(idx);
        end
      end
    end
    eligAfter = eligible | eligSetV;
  end

  // squash walk from the young end
  logic [IDX_W-1:0] squashTail;
  always_comb begin
    logic [IDX_W-1:0] idx;
    logic stop;
    squashTail = tailPtr;
    idx = wrapDec(tailPtr);
    stop = !squashValid;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        if (squashTail == headPtr || eligAfter[idx] || entSeq[idx] <= squashSeq) stop = 1'b1;
        else begin
          squashTail = idx;
          idx = wrapDec(idx);
        end
      end
    end
  end

  // writeback walk
  logic [SLOTS-1:0] sentSetV, zeroDoneV;
  logic [CNT_W-1:0] zeroCnt;
  logic [IDX_W-1:0] wbNext;
  always_comb begin
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] pending;
    logic [LANE_W-1:0] lane;
    logic stop;
    sentSetV = '0;
    zeroDoneV = '0;
    zeroCnt = '0;
    laneValid = '0;
    laneIdx = '0;
    idx = wbPtr;
    pending = toWrite;
    lane = '0;
    stop = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        if (pending == '0 || idx == tailPtr || !eligible[idx]) stop = 1'b1;
        else if (entSize[idx] == 4'd0) begin
          zeroDoneV[idx] = 1'b1;
          zeroCnt = zeroCnt + 1'b1;
          pending = pending - 1'b1;
          idx = wrapInc(idx);
        end else if (cacheBlocked || lane == LANE_W'(PORTS)) stop = 1'b1;
        else begin
          laneValid[lane] = 1'b1;
          laneIdx[lane*IDX_W +: IDX_W] = idx;
          sentSetV[idx] = 1'b1;
          lane = lane + 1'b1;
          idx = wrapInc(idx);
        end
      end
    end
    wbNext = idx;
  end

  // completion and in-order release
  logic [SLOTS-1:0] rspDoneV, doneAfter, relMask;
  logic [IDX_W-1:0] headNext;
  always_comb begin
    logic [IDX_W-1:0] h;
    logic stop;
    rspDoneV = '0;
    if (rspValid && sent[rspIdx]) rspDoneV[rspIdx] = 1'b1;
    doneAfter = done | zeroDoneV | rspDoneV;
    relMask = '0;
    h = headPtr;
    stop = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        if (h != tailPtr && doneAfter[h]) begin
          relMask[h] = 1'b1;
          h = wrapInc(h);
        end else stop = 1'b1;
      end
    end
    headNext = h;
  end

  logic allocOk;
  assign full     = (wrapInc(tailPtr) == headPtr);
  assign allocOk  = allocValid && !squashValid && !full;
  assign allocIdx = tailPtr;
  assign count    = (tailPtr >= headPtr) ? CNT_W'(tailPtr - headPtr)
                                         : CNT_W'(SLOTS - int'(headPtr) + int'(tailPtr));

  always_comb begin
    strobe.allocWe  = allocOk;
    strobe.allocIdx = tailPtr;
    strobe.eligSet  = eligSetV;
    strobe.sentSet  = sentSetV;
    strobe.doneSet  = zeroDoneV | rspDoneV;
    strobe.relClr   = relMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      wbPtr   <= '0;
      tailPtr <= '0;
      toWrite <= '0;
    end else begin
      headPtr <= headNext;
      wbPtr   <= wbNext;
      if (squashValid) tailPtr <= squashTail;
      else if (allocOk) tailPtr <= wrapInc(tailPtr);
      toWrite <= toWrite + marks - zeroCnt - CNT_W'(|rspDoneV);
    end
  end
endmodule

// File: rtl/sq_data.sv
module sq_data #(
  parameter int SLOTS  = 5,
  parameter int PORTS  = 2,
  parameter int SEQ_W  = 16,
  parameter int LQ_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3,
  parameter type strobe_t = logic
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [SEQ_W-1:0]        allocSeq,
  input  logic [LQ_W-1:0]         allocLqTag,
  input  logic [ADDR_W-1:0]       allocAddr,
  input  logic [DATA_W-1:0]       allocData,
  input  logic [3:0]              allocSize,
  input  logic [PORTS-1:0]        laneValid,
  input  logic [PORTS*IDX_W-1:0]  laneIdx,
  output logic [SEQ_W-1:0]        entSeq [SLOTS],
  output logic [3:0]              entSize [SLOTS],
  output logic [SLOTS-1:0]        eligible,
  output logic [SLOTS-1:0]        sent,
  output logic [SLOTS-1:0]        done,
  output logic [PORTS*IDX_W-1:0]  reqIdx,
  output logic [PORTS*ADDR_W-1:0] reqAddr,
  output logic [PORTS*DATA_W-1:0] reqData,
  output logic [PORTS*4-1:0]      reqSize,
  output logic [PORTS*LQ_W-1:0]   reqLqTag,
  output logic                    sizeError
);
  logic [LQ_W-1:0]   entLq   [SLOTS];
  logic [ADDR_W-1:0] entAddr [SLOTS];
  logic [DATA_W-1:0] entData [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.allocWe && strobe.allocIdx == IDX_W'(i)) begin
        entSeq[i]  <= allocSeq;
        entLq[i]   <= allocLqTag;
        entAddr[i] <= allocAddr;
        entData[i] <= allocData;
        entSize[i] <= allocSize;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        eligible[i] <= 1'b0;
        sent[i]     <= 1'b0;
        done[i]     <= 1'b0;
      end else if ((strobe.allocWe && strobe.allocIdx == IDX_W'(i)) || strobe.relClr[i]) begin
        eligible[i] <= 1'b0;
        sent[i]     <= 1'b0;
        done[i]     <= 1'b0;
      end else begin
        eligible[i] <= eligible[i] | strobe.eligSet[i];
        sent[i]     <= sent[i] | strobe.sentSet[i];
        done[i]     <= done[i] | strobe.doneSet[i];
      end
    end
  end

  logic [PORTS-1:0] laneBad;
  for (genvar l = 0; l < PORTS; l++) begin : g_lane
    logic [IDX_W-1:0] sel;
    assign sel = laneIdx[l*IDX_W +: IDX_W];
    assign reqIdx[l*IDX_W +: IDX_W]    = sel;
    assign reqAddr[l*ADDR_W +: ADDR_W] = laneValid[l] ? entAddr[sel] : '0;
    assign reqData[l*DATA_W +: DATA_W] = laneValid[l] ? entData[sel] : '0;
    assign reqSize[l*4 +: 4]           = laneValid[l] ? entSize[sel] : '0;
    assign reqLqTag[l*LQ_W +: LQ_W]    = laneValid[l] ? entLq[sel] : '0;
    assign laneBad[l] = laneValid[l] && !sq_pkg::sizeLegal(entSize[sel]);
  end
  assign sizeError = |laneBad;
endmodule

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH  = 4,
  parameter int PORTS  = 2,
  parameter int SEQ_W  = 16,
  parameter int LQ_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int SLOTS = DEPTH + 1,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    allocValid,
  input  logic [SEQ_W-1:0]        allocSeq,
  input  logic [LQ_W-1:0]         allocLqTag,
  input  logic [ADDR_W-1:0]       allocAddr,
  input  logic [DATA_W-1:0]       allocData,
  input  logic [3:0]              allocSize,
  output logic [IDX_W-1:0]        allocIdx,
  output logic                    full,
  output logic [CNT_W-1:0]        count,
  input  logic                    commitValid,
  input  logic [SEQ_W-1:0]        commitSeq,
  input  logic                    squashValid,
  input  logic [SEQ_W-1:0]        squashSeq,
  input  logic                    cacheBlocked,
  output logic [PORTS-1:0]        reqValid,
  output logic [PORTS*IDX_W-1:0]  reqIdx,
  output logic [PORTS*ADDR_W-1:0] reqAddr,
  output logic [PORTS*DATA_W-1:0] reqData,
  output logic [PORTS*4-1:0]      reqSize,
  output logic [PORTS*LQ_W-1:0]   reqLqTag,
  output logic                    sizeError,
  input  logic                    rspValid,
  input  logic [IDX_W-1:0]        rspIdx
);
  typedef struct packed {
    logic             allocWe;
    logic [IDX_W-1:0] allocIdx;
    logic [SLOTS-1:0] eligSet;
    logic [SLOTS-1:0] sentSet;
    logic [SLOTS-1:0] doneSet;
    logic [SLOTS-1:0] relClr;
  } strobe_t;

  strobe_t                strobe;
  logic [SEQ_W-1:0]       entSeq  [SLOTS];
  logic [3:0]             entSize [SLOTS];
  logic [SLOTS-1:0]       eligible, sent, done;
  logic [PORTS*IDX_W-1:0] laneIdx;

  sq_ctrl #(.SLOTS(SLOTS), .PORTS(PORTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W),
            .CNT_W(CNT_W), .strobe_t(strobe_t)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .cacheBlocked(cacheBlocked), .rspValid(rspValid), .rspIdx(rspIdx),
    .entSeq(entSeq), .entSize(entSize), .eligible(eligible), .sent(sent), .done(done),
    .strobe(strobe), .laneValid(reqValid), .laneIdx(laneIdx),
    .allocIdx(allocIdx), .full(full), .count(count)
  );

  sq_data #(.SLOTS(SLOTS), .PORTS(PORTS), .SEQ_W(SEQ_W), .LQ_W(LQ_W),
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
            .strobe_t(strobe_t)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocSeq(allocSeq), .allocLqTag(allocLqTag), .allocAddr(allocAddr),
    .allocData(allocData), .allocSize(allocSize),
    .laneValid(reqValid), .laneIdx(laneIdx),
    .entSeq(entSeq), .entSize(entSize), .eligible(eligible), .sent(sent), .done(done),
    .reqIdx(reqIdx), .reqAddr(reqAddr), .reqData(reqData), .reqSize(reqSize),
    .reqLqTag(reqLqTag), .sizeError(sizeError)
  );
endmodule

// File: rtl/sq_checks.sv
module sq_checks #(
  parameter int DEPTH = 4,
  parameter int PORTS = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] count,
  input logic             full,
  input logic             allocValid,
  input logic             squashValid,
  input logic             cacheBlocked,
  input logic [PORTS-1:0] reqValid,
  input logic             sizeError
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (full && !squashValid) |=> count <= $past(count));

  assert_blocked_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    cacheBlocked |-> reqValid == '0);

  assert_lanes_packed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid & (reqValid + 1'b1)) == '0);

  assert_error_needs_lane_R7: assert property (@(posedge clk) disable iff (!rstN)
    sizeError |-> (reqValid != '0));

  assert_squash_no_grow_R10: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |=> count <= $past(count));

  assert_release_only_shrinks_R8: assert property (@(posedge clk) disable iff (!rstN)
    !allocValid |=> count <= $past(count));
endmodule

bind store_queue sq_checks #(.DEPTH(DEPTH), .PORTS(PORTS), .CNT_W(CNT_W)) u_checks (
  .clk(clk), .rstN(rstN), .count(count), .full(full), .allocValid(allocValid),
  .squashValid(squashValid), .cacheBlocked(cacheBlocked), .reqValid(reqValid),
  .sizeError(sizeError)
);

// File: tb/store_queue_test.sv
`timescale 1ns/1ps
module store_queue_test;
  localparam int DEPTH = 4, PORTS = 2, SEQ_W = 16, LQ_W = 4, ADDR_W = 32, DATA_W = 64;
  localparam int IDX_W = 3, CNT_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 0, commitValid = 0, squashValid = 0, cacheBlocked = 0, rspValid = 0;
  logic [SEQ_W-1:0] allocSeq = 0, commitSeq = 0, squashSeq = 0;
  logic [LQ_W-1:0] allocLqTag = 0;
  logic [ADDR_W-1:0] allocAddr = 0;
  logic [DATA_W-1:0] allocData = 0;
  logic [3:0] allocSize = 0;
  logic [IDX_W-1:0] rspIdx = 0;
  logic [IDX_W-1:0] allocIdx;
  logic full, sizeError;
  logic [CNT_W-1:0] count;
  logic [PORTS-1:0] reqValid;
  logic [PORTS*IDX_W-1:0] reqIdx;
  logic [PORTS*ADDR_W-1:0] reqAddr;
  logic [PORTS*DATA_W-1:0] reqData;
  logic [PORTS*4-1:0] reqSize;
  logic [PORTS*LQ_W-1:0] reqLqTag;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .PORTS(PORTS), .SEQ_W(SEQ_W), .LQ_W(LQ_W),
                .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocSeq(allocSeq),
    .allocLqTag(allocLqTag), .allocAddr(allocAddr), .allocData(allocData),
    .allocSize(allocSize), .allocIdx(allocIdx), .full(full), .count(count),
    .commitValid(commitValid), .commitSeq(commitSeq), .squashValid(squashValid),
    .squashSeq(squashSeq), .cacheBlocked(cacheBlocked), .reqValid(reqValid),
    .reqIdx(reqIdx), .reqAddr(reqAddr), .reqData(reqData), .reqSize(reqSize),
    .reqLqTag(reqLqTag), .sizeError(sizeError), .rspValid(rspValid), .rspIdx(rspIdx)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    allocValid = 0; commitValid = 0; squashValid = 0; rspValid = 0;
  endtask

  task automatic alloc(input int seq, input int size);
    allocValid = 1; allocSeq = SEQ_W'(seq); allocSize = 4'(size);
    allocAddr = ADDR_W'(32'h1000 + seq * 8); allocData = DATA_W'(seq * 3);
    allocLqTag = LQ_W'(seq);
    tick();
  endtask

  task automatic commit(input int seq);
    commitValid = 1; commitSeq = SEQ_W'(seq); tick();
  endtask

  task automatic squash(input int seq);
    squashValid = 1; squashSeq = SEQ_W'(seq); tick();
  endtask

  task automatic respond(input int idx);
    rspValid = 1; rspIdx = IDX_W'(idx); tick();
  endtask

  initial begin
    #80000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    check("R1", "count", count, 0);
    check("R1", "full", full, 0);
    check("R1", "allocIdx", allocIdx, 0);
    check("R1", "reqValid", reqValid, 0);

    // fill: seq 10..13 into slots 0..3
    for (int s = 0; s < 4; s++) begin
      check("R2", "allocIdx", allocIdx, s);
      alloc(10 + s, 4);
    end
    check("R2", "count full", count, 4);
    check("R2", "full", full, 1);
    alloc(14, 4);
    check("R2", "alloc while full ignored", count, 4);
    check("R2", "tail unchanged", allocIdx, 4);
    check("R3", "nothing eligible", reqValid, 0);

    commit(11);
    cacheBlocked = 1; #1;
    check("R5", "blocked no req", reqValid, 0);
    tick();
    check("R5", "still blocked", reqValid, 0);
    cacheBlocked = 0; #1;
    check("R4", "two lanes", reqValid, 2'b11);
    check("R4", "lane0 idx", reqIdx[IDX_W-1:0], 0);
    check("R4", "lane1 idx", reqIdx[2*IDX_W-1:IDX_W], 1);
    check("R4", "lane0 addr", reqAddr[ADDR_W-1:0], 32'h1000 + 10 * 8);
    check("R4", "lane1 data", reqData[2*DATA_W-1:DATA_W], 11 * 3);
    check("R7", "legal size no error", sizeError, 0);
    tick();
    check("R3", "seq 12 not committed", reqValid, 0);

    squash(10);
    check("R9", "stop at eligible", count, 2);
    check("R9", "tail after squash", allocIdx, 2);

    respond(1);
    check("R8", "younger ack no release", count, 2);
    respond(0);
    check("R8", "head ack releases both", count, 0);

    // wrap case
    alloc(20, 8); alloc(21, 8); alloc(22, 8);
    allocValid = 1; allocSeq = 23; allocSize = 8;
    squashValid = 1; squashSeq = 99;
    tick();
    check("R10", "squash beats alloc", count, 3);
    check("R11", "next slot wraps", allocIdx, 0);
    alloc(23, 8);
    check("R11", "tail wrapped", allocIdx, 1);
    check("R2", "full again", full, 1);
    commit(23);
    check("R4", "port limit lanes", reqValid, 2'b11);
    check("R11", "lane0 slot 2", reqIdx[IDX_W-1:0], 2);
    check("R11", "lane1 slot 3", reqIdx[2*IDX_W-1:IDX_W], 3);
    tick();
    check("R4", "second batch", reqValid, 2'b11);
    check("R11", "lane0 slot 4", reqIdx[IDX_W-1:0], 4);
    check("R11", "lane1 slot 0", reqIdx[2*IDX_W-1:IDX_W], 0);
    tick();
    check("R4", "drained", reqValid, 0);
    respond(0);
    check("R8", "ack slot0 held", count, 4);
    respond(4);
    check("R8", "ack slot4 held", count, 4);
    respond(3);
    check("R8", "ack slot3 held", count, 4);
    respond(2);
    check("R8", "head ack releases all", count, 0);

    // squash by sequence, zero size and illegal size
    alloc(40, 0); alloc(41, 4); alloc(42, 3); alloc(45, 4);
    squash(42);
    check("R9", "stop at older seq", count, 3);
    commit(41);
    check("R3", "commit stops at 42", reqValid, 2'b01);
    check("R6", "zero store skips lane", reqIdx[IDX_W-1:0], 2);
    check("R7", "no error", sizeError, 0);
    tick();
    check("R6", "zero store released", count, 2);
    commit(42);
    check("R7", "illegal size lane", reqValid, 2'b01);
    check("R7", "size error", sizeError, 1);
    check("R7", "size value", reqSize[3:0], 3);
    tick();
    check("R7", "error clears", sizeError, 0);
    respond(3);
    check("R8", "slot3 ack held", count, 2);
    respond(2);
    check("R8", "all released", count, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule